// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt sources into 31 groups of four request bits each. Groups 0 and 1 carry non-maskable requests. Groups 2 to 30 are maskable, and each of these has its own enable nibble and a 3-bit priority level. A source strobe sets its request bit, and the bit stays set until software clears it through the byte-wide register bus. Groups 2 to 30 are resolved continuously into a 3-bit level for the processor. A lower number means a more urgent request, and 7 means that nothing is pending.

When the processor takes an interrupt, it acknowledges with the level it saw. If that level matches the level being driven, the controller records the winning group in an accepted-group register that software can read. If it does not match, a sticky error flag is raised and the recorded group stays as it was. Any strobe on an NMI group source produces a single-cycle NMI pulse.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Source input n maps to group n/4, bit n%4. A one-cycle high on it sets that request bit, and the bit stays set until a register write clears it.
- R2: Group g, byte b sits at register offset 4*g+b. Offsets 0x7C to 0x7F and any unmapped offset read 0. The accepted-group register is at 0x80 (byte 0) and 0x81 (byte 1).
- R3: A read of maskable group byte 0 returns request in [7:4] and request AND enable in [3:0]. A read of byte 1 returns level in [6:4], 0 in bit 7 and enable in [3:0]. Bytes 2 and 3 read 0, and writes to them change nothing.
- R4: A write to maskable group byte 0 acts on each bit i separately. If wdata[i] is 0, request bit i is kept. If wdata[i] is 1 and wdata[i+4] is 1, the bit is set. If wdata[i] is 1 and wdata[i+4] is 0, the bit is cleared.
- R5: A write to maskable group byte 1 loads the level from wdata[6:4] and the enable from wdata[3:0].
- R6: Only groups 2 to 30 with request AND enable nonzero take part. The smallest level wins, and on a tie the smallest group number wins. irq_level is 7 when no group qualifies. It reflects the state registered at the edge that captured the stimulus.
- R7: NMI groups have a fixed enable of 0xF. Byte 0 reads the request bits in [3:0] with 0 above them. Writing 1s to byte 0 clears the matching bits. Bytes 1 to 3 read 0 and ignore writes.
- R8: A strobe on any NMI group source gives nmi_pulse high for exactly the one cycle after the edge that captured it.
- R9: On ack_valid with ack_level equal to irq_level, the selected group is latched. Byte 0 at 0x80 reads that group number times 4, or 0 if that group's request AND enable is now zero. 0x81 reads 0, and writes to 0x80 and 0x81 are ignored.
- R10: An ack_valid whose ack_level differs from irq_level sets ack_err, which stays set until reset. The latched group is left unchanged.
- R11: After reset, all requests are clear, maskable enables and levels are 0, irq_level is 7, nmi_pulse and ack_err are 0, and 0x80 reads 0.
- R12: When a source strobe and a clearing write hit the same request bit in the same cycle, the bit ends up set.
- R13: reg_rdata is combinational from reg_rd and reg_addr in the same cycle, and it is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 124 | Per-source request strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, same cycle |
| ack_valid | input | 1 | Processor acknowledge |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest pending level, 7 when idle |
| nmi_pulse | output | 1 | One-cycle non-maskable request |
| ack_err | output | 1 | Sticky acknowledge mismatch flag |

## Verification
Request, enable, level and accepted-group state all change at the edge that samples the strobe. irq_level is combinational from that state, so it is valid one edge after the stimulus. nmi_pulse is registered and is high only in the cycle after the source strobe. Read data appears in the cycle of the strobe. The bench therefore drives every stimulus on a falling edge and samples outputs on the following falling edge, after exactly one rising edge. Reads are driven and sampled within a single low phase.

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NUM_GROUPS = 31,
  parameter int NMI_GROUPS = 2,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ACC_ADDR = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*4-1:0] src_req,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    ack_valid,
  input  logic [2:0]              ack_level,
  output logic [2:0]              irq_level,
  output logic                    nmi_pulse,
  output logic                    ack_err
);
  localparam int GID_W = $clog2(NUM_GROUPS);
  localparam logic [ADDR_W-3:0] GRP_LIM = (ADDR_W-2)'(NUM_GROUPS);
  localparam logic [2:0] IDLE_LVL = 3'd7;

  logic [NUM_GROUPS-1:0][3:0] req_q, req_d, en_q, en_d;
  logic [NUM_GROUPS-1:0][2:0] lvl_q, lvl_d;
  logic [GID_W-1:0] acc_q, sel_gid;
  logic [2:0]       sel_lvl;

  wire [ADDR_W-3:0] a_grp  = reg_addr[ADDR_W-1:2];
  wire [1:0]        a_byte = reg_addr[1:0];
  wire              a_hit  = a_grp < GRP_LIM;
  wire [GID_W-1:0]  gidx   = a_grp[GID_W-1:0];
  wire              nmi_hit = |src_req[4*NMI_GROUPS-1:0];
  wire              acc_live = |(req_q[acc_q] & en_q[acc_q]);

  always_comb begin
    sel_gid = '0;
    sel_lvl = IDLE_LVL;
    for (int g = NMI_GROUPS; g < NUM_GROUPS; g++)
      if (|(req_q[g] & en_q[g]) && lvl_q[g] < sel_lvl) begin
        sel_gid = GID_W'(g);
        sel_lvl = lvl_q[g];
      end
  end

  assign irq_level = sel_lvl;

  always_comb begin
    req_d = req_q;
    en_d  = en_q;
    lvl_d = lvl_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_wr && a_hit && gidx == GID_W'(g)) begin
        if (g < NMI_GROUPS) begin
          if (a_byte == 2'd0) req_d[g] = req_q[g] & ~reg_wdata[3:0];
        end else if (a_byte == 2'd0) begin
          req_d[g] = (reg_wdata[7:4] & reg_wdata[3:0]) | (req_q[g] & ~reg_wdata[3:0]);
        end else if (a_byte == 2'd1) begin
          en_d[g]  = reg_wdata[3:0];
          lvl_d[g] = reg_wdata[6:4];
        end
      end
      req_d[g] = req_d[g] | src_req[4*g +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        req_q[g] <= '0;
        en_q[g]  <= (g < NMI_GROUPS) ? 4'hF : 4'h0;
        lvl_q[g] <= '0;
      end
      acc_q     <= '0;
      ack_err   <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      req_q     <= req_d;
      en_q      <= en_d;
      lvl_q     <= lvl_d;
      nmi_pulse <= nmi_hit;
      if (ack_valid) begin
        if (ack_level == sel_lvl) acc_q <= sel_gid;
        else                      ack_err <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (a_hit) begin
        if (gidx < GID_W'(NMI_GROUPS)) begin
          if (a_byte == 2'd0) reg_rdata = {4'h0, req_q[gidx]};
        end else begin
          case (a_byte)
            2'd0: reg_rdata = {req_q[gidx], req_q[gidx] & en_q[gidx]};
            2'd1: reg_rdata = {1'b0, lvl_q[gidx], en_q[gidx]};
            default: reg_rdata = '0;
          endcase
        end
      end else if (reg_addr == ACC_ADDR) begin
        reg_rdata = acc_live ? 8'({acc_q, 2'b00}) : 8'h00;
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk #(
  parameter int NUM_GROUPS = 31,
  parameter int NMI_GROUPS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_GROUPS*4-1:0] src_req,
  input logic                    reg_rd,
  input logic [7:0]              reg_rdata,
  input logic                    ack_valid,
  input logic [2:0]              ack_level,
  input logic [2:0]              irq_level,
  input logic                    nmi_pulse,
  input logic                    ack_err
);
  wire nmi_in = |src_req[4*NMI_GROUPS-1:0];

  // R8
  nmi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_in |=> nmi_pulse);
  // R8
  nmi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_in |=> !nmi_pulse);
  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != irq_level) |=> ack_err);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_err && !(ack_valid && ack_level != irq_level)) |=> !ack_err);
  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 8'h00);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS), .NMI_GROUPS(NMI_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
  .nmi_pulse(nmi_pulse), .ack_err(ack_err)
);

// File: tb/sim_grp_irq_ctrl.sv
module sim_grp_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [123:0] src_req = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, ack_valid = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [2:0] ack_level = '0;
  logic [7:0] reg_rdata;
  logic [2:0] irq_level;
  logic nmi_pulse, ack_err;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  grp_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
    .ack_level(ack_level), .irq_level(irq_level), .nmi_pulse(nmi_pulse), .ack_err(ack_err));

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a; #1; d = reg_rdata; reg_rd = 1'b0; #1;
  endtask

  task automatic src(input int n);
    @(negedge clk); src_req[n] = 1'b1;
    @(negedge clk); src_req[n] = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk); ack_valid = 1'b1; ack_level = l;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk);
    chk("R11 idle level", irq_level, 7);
    chk("R11 nmi low", nmi_pulse, 0);
    chk("R11 err low", ack_err, 0);
    rd(8'h09, d); chk("R11 g2 level/enable", d, 8'h00);
    rd(8'h00, d); chk("R11 g0 request", d, 8'h00);
    rd(8'h80, d); chk("R11 accepted", d, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] d;
    src(22);
    rd(8'h14, d); chk("R1 g5 bit2 set, masked", d, 8'h40);
    chk("R6 disabled not pending", irq_level, 7);
    @(negedge clk);
    rd(8'h14, d); chk("R1 request held", d, 8'h40);
    wr(8'h15, 8'h34);
    rd(8'h15, d); chk("R5 level/enable readback", d, 8'h34);
    rd(8'h14, d); chk("R3 byte0 request and masked", d, 8'h44);
    chk("R6 level 3 driven", irq_level, 3);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    src(36);
    wr(8'h25, 8'h31);
    chk("R6 tie level", irq_level, 3);
    ack(3'd3);
    rd(8'h80, d); chk("R6 tie lowest group wins, R9 latch", d, 8'h14);
    wr(8'h25, 8'h11);
    chk("R6 lower level wins", irq_level, 1);
    ack(3'd1);
    rd(8'h80, d); chk("R9 accepted g9", d, 8'h24);
  endtask

  task automatic t_byte0;
    logic [7:0] d;
    wr(8'h24, 8'h01);
    rd(8'h24, d); chk("R4 clear bit0", d, 8'h00);
    chk("R6 back to g5", irq_level, 3);
    rd(8'h80, d); chk("R9 vanished request reads 0", d, 8'h00);
    wr(8'h24, 8'h22);
    rd(8'h24, d); chk("R4 set bit1", d, 8'h20);
    wr(8'h24, 8'h80);
    rd(8'h24, d); chk("R4 no id bit keeps", d, 8'h20);
    wr(8'h26, 8'hFF);
    rd(8'h25, d); chk("R3 byte2 write ignored", d, 8'h11);
    rd(8'h26, d); chk("R3 byte2 reads 0", d, 8'h00);
    rd(8'h24, d); chk("R3 byte2 write no request change", d, 8'h20);
  endtask

  task automatic t_nmi;
    logic [7:0] d;
    @(negedge clk); src_req[1] = 1'b1;
    @(negedge clk); src_req[1] = 1'b0;
    chk("R8 nmi pulse", nmi_pulse, 1);
    @(negedge clk);
    chk("R8 nmi one cycle", nmi_pulse, 0);
    rd(8'h00, d); chk("R7 g0 request", d, 8'h02);
    wr(8'h01, 8'h7F);
    rd(8'h01, d); chk("R7 byte1 reads 0", d, 8'h00);
    chk("R7 nmi groups not in level", irq_level, 3);
    wr(8'h00, 8'h02);
    rd(8'h00, d); chk("R7 write-1 clears", d, 8'h00);
  endtask

  task automatic t_ack_err;
    logic [7:0] d;
    ack(3'd3);
    rd(8'h80, d); chk("R9 accepted g5", d, 8'h14);
    chk("R10 no err on match", ack_err, 0);
    ack(3'd6);
    chk("R10 err set", ack_err, 1);
    rd(8'h80, d); chk("R10 accepted unchanged", d, 8'h14);
    repeat (3) @(negedge clk);
    chk("R10 err sticky", ack_err, 1);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk);
    src_req[21] = 1'b1; reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 8'h02;
    @(negedge clk);
    src_req[21] = 1'b0; reg_wr = 1'b0;
    rd(8'h14, d); chk("R12 set beats clear", d, 8'h64);
  endtask

  task automatic t_map_edges;
    logic [7:0] d;
    rd(8'h7C, d); chk("R2 unmapped group 31", d, 8'h00);
    rd(8'h81, d); chk("R9 accepted byte1", d, 8'h00);
    rd(8'hC0, d); chk("R2 unmapped high", d, 8'h00);
    wr(8'h80, 8'hFF);
    rd(8'h80, d); chk("R9 accepted write ignored", d, 8'h14);
    reg_addr = 8'h14; #1;
    chk("R13 no strobe zero", reg_rdata, 8'h00);
    rd(8'h78, d); chk("R2 g30 byte0 offset", d, 8'h00);
    src(120);
    rd(8'h78, d); chk("R1 R2 source 120 to g30", d, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_prio;
    t_byte0;
    t_nmi;
    t_ack_err;
    t_collide;
    t_map_edges;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule